// File: doc/BRIEF.md
# PWM Channel Enable and Clock Gating Front End

This block sits ahead of a four-channel pulse-width modulator. It holds one enable bit per channel in a small register on a strobe-based bus. It runs a shared prescaler that produces single-cycle tick pulses at power-of-two division rates. For every channel it passes the tick of that channel's selected rate through a gate, so that the channel's downstream counter logic gets a clock enable only while the channel is switched on.

The block also drives the channel's port pin. While a channel is enabled, its pin is forced to be an output. The stored direction setting is never rewritten, so clearing the enable hands pin direction back to the direction input at once. A channel's modulated waveform reaches the pin only after that channel's gated clock has begun a new cycle. Until then, and whenever the channel is off, the pin carries the port data value.

The prescaler counts only while some channel is enabled or still armed, and it sits at zero otherwise.

Top module: `pwm_gate_front`

## Requirements
- R1: The enable register holds one bit per channel in bits 3..0 (bit c belongs to channel c). Bits 7..4 always read as zero, and every bit is zero after reset.
- R2: A write strobe stores `wr_data[3:0]` at the next clock edge in any state, and a read strobe returns the stored enables in the same cycle. `rd_data` is zero when no read strobe is present.
- R3: While a channel's enable bit is one, its `pin_oe` bit is one whatever `port_dir` holds.
- R4: While a channel's enable bit is zero, its `pin_oe` equals its `port_dir` bit. Toggling enables never alters the direction seen at the pins.
- R5: `chan_clk_en[c]` is high only in a cycle where the prescaler tick for channel c's rate is high and the channel's enable bit is one. It is never high between ticks.
- R6: The prescaler counts only while some enable bit or armed flag is set. Otherwise it holds at zero, so after a restart the first tick at rate k comes in the 2^k-th running cycle.
- R7: `pin_out[c]` equals `pwm_raw[c]` when channel c is both enabled and armed. Otherwise it equals `port_data[c]`.
- R8: A channel's armed flag copies its enable bit only in a cycle where that channel's tick is high. The waveform therefore appears on the pin from the cycle after the first gated pulse that follows the enable.
- R9: The rate field for channel c is `chan_rate[3c+2:3c]`, holding a value k from 0 to 7. Ticks at rate k recur every 2^k running cycles, and at k = 0 there is a tick in every running cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Enable register write strobe |
| rd_en | input | 1 | Enable register read strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data, upper bits zero |
| chan_rate | input | 12 | Per-channel rate exponent, 3 bits per channel |
| pwm_raw | input | 4 | Raw modulated waveform per channel |
| port_data | input | 4 | Port data register bits for the four pins |
| port_dir | input | 4 | Port direction register bits, 1 = output |
| chan_clk_en | output | 4 | Gated per-channel clock enable pulses |
| pin_out | output | 4 | Pin output values |
| pin_oe | output | 4 | Pin output enables |

## Verification
The hardest situation to reach is a clean restart of the prescaler. Every enable must be cleared, and then every armed flag must drain. Draining can take up to 128 cycles for a slow channel, because a flag drops only on its own channel's next tick. After that the bench re-enables a single rate-7 channel and measures the exact distance to its first gated pulse. The bench also sweeps all sixteen enable patterns under two rate assignments, with pseudo-random waveform, data and direction inputs. A cycle-level arithmetic model predicts every output bit.

// File: rtl/pwm_gate_pkg.sv
package pwm_gate_pkg;
   localparam int RATE_W = 3;
   localparam int NRATE  = 1 << RATE_W;
   typedef logic [RATE_W-1:0] rate_t;
endpackage

// File: rtl/pwm_en_reg.sv
module pwm_en_reg #(
   parameter int NCH    = 4,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rd_data,
   output logic [NCH-1:0]    en_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         en_q <= '0;
      else if (wr_en)
         en_q <= wr_data[NCH-1:0];
   end

   // unused upper bits read back as zero
   always_comb begin
      rd_data = '0;
      if (rd_en)
         rd_data[NCH-1:0] = en_q;
   end

   assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> en_q == $past(wr_data[NCH-1:0]));
endmodule

// File: rtl/pwm_prescaler.sv
module pwm_prescaler
   import pwm_gate_pkg::*;
#(
   parameter int PRESC_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   output logic [NRATE-1:0] ticks
);
   logic [PRESC_W-1:0] cnt;

   // counter sits at zero whenever nothing needs it
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (!run)
         cnt <= '0;
      else
         cnt <= cnt + 1'b1;
   end

   for (genvar k = 0; k < NRATE; k++) begin : g_rate
      if (k == 0) begin : g_full
         assign ticks[k] = run;
      end else begin : g_div
         assign ticks[k] = run & (&cnt[k-1:0]);
         assert_tick_spacing_R9: assert property (@(posedge clk) disable iff (!rst_n)
            ticks[k] |=> !ticks[k]);
      end
   end

   assert_restart_from_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(run) |-> cnt == '0);
endmodule

// File: rtl/pwm_chan_gate.sv
module pwm_chan_gate
   import pwm_gate_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NRATE-1:0] ticks,
   input  rate_t            rate_sel,
   input  logic             en_bit,
   input  logic             pwm_raw,
   input  logic             port_data,
   input  logic             port_dir,
   output logic             clk_en,
   output logic             armed,
   output logic             pin_out,
   output logic             pin_oe
);
   logic tick_sel;

   assign tick_sel = ticks[rate_sel];
   assign clk_en   = tick_sel & en_bit;

   // the armed flag follows the enable only at a cycle boundary of this channel
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         armed <= 1'b0;
      else if (tick_sel)
         armed <= en_bit;
   end

   assign pin_oe  = en_bit | port_dir;
   assign pin_out = (en_bit & armed) ? pwm_raw : port_data;

   assert_arm_on_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(armed) |-> $past(tick_sel));
   assert_disarm_on_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(armed) |-> $past(tick_sel));
endmodule

// File: rtl/pwm_gate_front.sv
module pwm_gate_front
   import pwm_gate_pkg::*;
#(
   parameter int NCH     = 4,
   parameter int DATA_W  = 8,
   parameter int PRESC_W = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic                  rd_en,
   input  logic [DATA_W-1:0]     wr_data,
   output logic [DATA_W-1:0]     rd_data,
   input  logic [NCH*RATE_W-1:0] chan_rate,
   input  logic [NCH-1:0]        pwm_raw,
   input  logic [NCH-1:0]        port_data,
   input  logic [NCH-1:0]        port_dir,
   output logic [NCH-1:0]        chan_clk_en,
   output logic [NCH-1:0]        pin_out,
   output logic [NCH-1:0]        pin_oe
);
   if (NCH < 1 || NCH > DATA_W) begin : g_bad_nch
      $error("pwm_gate_front: NCH must lie in 1..DATA_W");
   end
   if (PRESC_W < NRATE - 1) begin : g_bad_presc
      $error("pwm_gate_front: PRESC_W too narrow for the slowest rate");
   end

   logic [NCH-1:0]   en_q;
   logic [NCH-1:0]   armed;
   logic [NRATE-1:0] ticks;
   logic             run;

   pwm_en_reg #(.NCH(NCH), .DATA_W(DATA_W)) u_reg (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_en),
      .wr_data(wr_data),
      .rd_en  (rd_en),
      .rd_data(rd_data),
      .en_q   (en_q)
   );

   assign run = (|en_q) | (|armed);

   pwm_prescaler #(.PRESC_W(PRESC_W)) u_presc (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (run),
      .ticks(ticks)
   );

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      rate_t rsel;
      assign rsel = chan_rate[c*RATE_W +: RATE_W];

      pwm_chan_gate u_gate (
         .clk      (clk),
         .rst_n    (rst_n),
         .ticks    (ticks),
         .rate_sel (rsel),
         .en_bit   (en_q[c]),
         .pwm_raw  (pwm_raw[c]),
         .port_data(port_data[c]),
         .port_dir (port_dir[c]),
         .clk_en   (chan_clk_en[c]),
         .armed    (armed[c]),
         .pin_out  (pin_out[c]),
         .pin_oe   (pin_oe[c])
      );

      assert_pulse_on_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
         chan_clk_en[c] |-> ticks[rsel]);
      assert_forced_output_R3: assert property (@(posedge clk) disable iff (!rst_n)
         en_q[c] |-> pin_oe[c]);
      assert_dir_passthrough_R4: assert property (@(posedge clk) disable iff (!rst_n)
         !en_q[c] |-> pin_oe[c] == port_dir[c]);
   end

   assert_idle_no_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !run |-> chan_clk_en == '0);
   assert_upper_read_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[DATA_W-1:NCH] == '0);
endmodule

// File: tb/pwm_gate_front_test.sv
module pwm_gate_front_test;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        wr_en, rd_en;
   logic [7:0]  wr_data;
   logic [7:0]  rd_data;
   logic [11:0] chan_rate;
   logic [3:0]  pwm_raw, port_data, port_dir;
   logic [3:0]  chan_clk_en, pin_out, pin_oe;

   int vectors = 0;
   int fails   = 0;
   bit done    = 0;
   logic [15:0] lfsr = 16'hACE1;

   always #5 clk = ~clk;

   pwm_gate_front uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
      .wr_data(wr_data), .rd_data(rd_data), .chan_rate(chan_rate),
      .pwm_raw(pwm_raw), .port_data(port_data), .port_dir(port_dir),
      .chan_clk_en(chan_clk_en), .pin_out(pin_out), .pin_oe(pin_oe)
   );

   // arithmetic reference state
   logic [3:0] m_en, m_act;
   int         m_cnt;

   function automatic bit m_run();
      return (m_en != 0) || (m_act != 0);
   endfunction

   function automatic bit m_tick(int c);
      int k = int'(chan_rate[c*3 +: 3]);
      int p = 1 << k;
      return m_run() && ((m_cnt % p) == p - 1);
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_en  <= '0;
         m_act <= '0;
         m_cnt <= 0;
      end else begin
         for (int c = 0; c < 4; c++)
            if (m_tick(c)) m_act[c] <= m_en[c];
         if (wr_en) m_en <= wr_data[3:0];
         m_cnt <= m_run() ? ((m_cnt + 1) & 255) : 0;
      end
   end

   task automatic check_outputs();
      logic [3:0] e_clk, e_oe, e_out;
      logic [7:0] e_rd;
      for (int c = 0; c < 4; c++) begin
         e_clk[c] = m_tick(c) && m_en[c];
         e_oe[c]  = m_en[c] | port_dir[c];
         e_out[c] = (m_en[c] & m_act[c]) ? pwm_raw[c] : port_data[c];
      end
      e_rd = rd_en ? {4'b0, m_en} : 8'h00;
      vectors++;
      if (chan_clk_en !== e_clk) begin
         fails++; $display("FAIL R5/R9 chan_clk_en act=%b exp=%b", chan_clk_en, e_clk);
      end
      if (pin_oe !== e_oe) begin
         fails++; $display("FAIL R3/R4 pin_oe act=%b exp=%b", pin_oe, e_oe);
      end
      if (pin_out !== e_out) begin
         fails++; $display("FAIL R7/R8 pin_out act=%b exp=%b", pin_out, e_out);
      end
      if (rd_data !== e_rd) begin
         fails++; $display("FAIL R1/R2 rd_data act=%h exp=%h", rd_data, e_rd);
      end
   endtask

   task automatic step(input bit w, input logic [7:0] d, input bit r);
      @(negedge clk);
      check_outputs();
      lfsr      = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      pwm_raw   = lfsr[3:0];
      port_data = lfsr[7:4];
      port_dir  = lfsr[11:8];
      wr_en     = w;
      wr_data   = d;
      rd_en     = r;
   endtask

   task automatic single(input bit ok, input string tag, input int act, input int exp);
      vectors++;
      if (!ok) begin
         fails++; $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
      end
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         fails++;
         $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
         $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   initial begin
      int n;
      rst_n = 1'b0; wr_en = 0; rd_en = 0; wr_data = 0;
      pwm_raw = 0; port_data = 0; port_dir = 0;
      chan_rate = {3'd5, 3'd3, 3'd1, 3'd0};
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      rd_en = 1;
      #1;
      single(rd_data == 8'h00, "R1 reset read", rd_data, 0);
      single(chan_clk_en == 4'h0, "R5 reset pulses", chan_clk_en, 0);
      // sweep all enable patterns, junk in upper bits (R1, R2)
      for (int pass = 0; pass < 2; pass++) begin
         for (int v = 0; v < 16; v++) begin
            step(1, 8'hA0 | 8'(v), 1);
            for (int i = 0; i < 40; i++) step(0, 8'hFF, (i % 3) == 0);
         end
         step(1, 8'h50, 1);
         for (int i = 0; i < 300; i++) step(0, 8'h00, 1);
         chan_rate = {3'd6, 3'd4, 3'd7, 3'd2};
         step(0, 8'h00, 0);
      end
      // R6: restart from zero; rate 7 on channel 3
      chan_rate = {3'd7, 3'd4, 3'd7, 3'd2};
      for (int i = 0; i < 300; i++) step(0, 8'h00, 0);
      step(1, 8'h08, 0);
      n = 0;
      for (int i = 0; i < 300; i++) begin
         step(0, 8'h00, 0);
         n++;
         #1;
         if (chan_clk_en[3]) break;
      end
      single(n == 128, "R6 first rate-7 pulse distance", n, 128);
      // R8: waveform not yet on pin during the first gated pulse cycle's aftermath check
      single(pin_out[3] == port_data[3], "R8 pin before arming", pin_out[3], port_data[3]);
      step(0, 8'h00, 0);
      #1;
      single(pin_out[3] == pwm_raw[3], "R8 pin after arming", pin_out[3], pwm_raw[3]);
      // R4: clearing enable returns direction to port_dir
      step(1, 8'h00, 1);
      step(0, 8'h00, 1);
      #1;
      single(pin_oe == port_dir, "R4 direction restored", pin_oe, port_dir);
      for (int i = 0; i < 200; i++) step(0, 8'h00, 0);
      #1;
      single(chan_clk_en == 4'h0, "R6 idle after drain", chan_clk_en, 0);
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule